// File: doc/BRIEF.md
# Word-Packed Transmit/Receive FIFO Controller

This block sits between a register bus and a serial bus engine and buffers 32-bit words in both directions. Software pushes header and payload words into a transmit queue through a write-only data port and pops received words from a receive queue through a read-only data port. The engine drains the transmit queue and fills the receive queue over a valid/ready word handshake. Each word carries four payload bytes; packing and unpacking of bytes happen outside this block.

A control register holds a per-direction flush request and a per-direction trigger level. A flush request stays readable as set while the flush is in progress and clears itself afterwards, so software can poll for completion. A status register reports free transmit slots and occupied receive slots. Two request outputs tell the interrupt logic when the transmit side has room or the receive side has enough data. Two sticky error outputs record a write into a full transmit queue and a read from an empty receive queue.

Top module: `wpfifo_ctrl`

## Requirements
- R1: After reset the status register reads 0x80 (8 free transmit slots, 0 received words), the control register reads 0, tx_req_o is 1, rx_req_o is 0, both error outputs are 0, eng_tx_valid_o is 0 and eng_rx_ready_o is 1.
- R2: Words written to bus address 0 leave on eng_tx_data_o in write order, one per cycle in which eng_tx_valid_o and eng_tx_ready_i are both 1; eng_tx_valid_o is 1 whenever the transmit queue holds a word and no transmit flush is pending.
- R3: Words accepted from the engine (eng_rx_valid_i and eng_rx_ready_o both 1) are returned on bus_rdata_o at bus address 1 in arrival order, and each bus read strobe at address 1 removes one word.
- R4: Bus address 3 returns the status: bits 7:4 hold the number of free transmit slots and bits 3:0 the number of stored received words; address 2 returns the control register.
- R5: A write to address 0 while the transmit queue holds 8 words is dropped, leaves the queue contents and order unchanged, and sets tx_ovf_o, which stays 1 until a transmit flush.
- R6: A read strobe at address 1 while the receive queue is empty returns 0, leaves the count unchanged and sets rx_unf_o, which stays 1 until a receive flush.
- R7: Writing control bit 1 (transmit) or bit 0 (receive) as 1 empties that queue one cycle after the write; the bit reads 1 for the two cycles after the write and 0 afterwards; the flush clears that direction's error flag and leaves the other queue untouched.
- R8: Control bits 7:5 hold the transmit trigger level and bits 4:2 the receive trigger level; tx_req_o is 1 while free transmit slots are at least the transmit level plus 1, and rx_req_o is 1 while stored received words are at least the receive level plus 1.
- R9: eng_rx_ready_o is 0 while the receive queue is full or a receive flush is pending, and an engine word offered while it is 0 is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (pops at address 1) |
| bus_addr_i | input | 2 | Register address: 0 tx data, 1 rx data, 2 control, 3 status |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for the current address |
| eng_tx_valid_o | output | 1 | Transmit word available to the engine |
| eng_tx_data_o | output | 32 | Transmit word at the head of the queue |
| eng_tx_ready_i | input | 1 | Engine takes the transmit word |
| eng_rx_valid_i | input | 1 | Engine offers a received word |
| eng_rx_data_i | input | 32 | Received word from the engine |
| eng_rx_ready_o | output | 1 | Receive queue accepts a word |
| tx_req_o | output | 1 | Transmit data request |
| rx_req_o | output | 1 | Receive data request |
| tx_ovf_o | output | 1 | Sticky transmit overflow flag |
| rx_unf_o | output | 1 | Sticky receive underflow flag |

## Verification
The bench builds the block with its default parameters: 32-bit words, 8 entries per direction and 3-bit trigger levels. With only 8 entries, both queues are driven to full and to empty within a few dozen cycles, so overflow, underflow, the full-side ready drop and both ends of the 4-bit count fields are all reached. The 3-bit levels let the bench set thresholds near the live counts, which places the request outputs on either side of their switching point.

// File: rtl/wpf_pkg.sv
package wpf_pkg;

    typedef enum logic [1:0] {
        ADR_TXDATA = 2'd0,
        ADR_RXDATA = 2'd1,
        ADR_CTRL   = 2'd2,
        ADR_STAT   = 2'd3
    } wpf_addr_e;

    // One flush sequence: pend is the software-visible bit, stage marks
    // that the queue has already been cleared.
    typedef struct packed {
        logic pend;
        logic stage;
    } flush_st_t;

    typedef struct packed {
        logic ovf;
        logic unf;
    } err_st_t;

endpackage

// File: rtl/wpf_fifo.sv
module wpf_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clear_i,
    input  logic                             push_i,
    input  logic [DATA_W-1:0]                push_data_i,
    input  logic                             pop_i,
    output logic [DATA_W-1:0]                head_o,
    output logic [$clog2(DEPTH+1)-1:0]       count_o,
    output logic                             full_o,
    output logic                             empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t          st_d, st_q;
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full_o  = (st_q.cnt == CNT_W'(DEPTH));
    assign empty_o = (st_q.cnt == '0);
    assign count_o = st_q.cnt;
    assign head_o  = mem_q[st_q.rd];

    always_comb begin
        st_d    = st_q;
        mem_d   = mem_q;
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (clear_i) begin
            st_d = '0;
        end else begin
            if (do_push) begin
                mem_d[st_q.wr] = push_data_i;
                st_d.wr        = ptr_next(st_q.wr);
            end
            if (do_pop) begin
                st_d.rd = ptr_next(st_q.rd);
            end
            st_d.cnt = st_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH)); // R4
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i && !clear_i) |=> full_o); // R5
    AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && pop_i && !push_i && !clear_i) |=> empty_o); // R6
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> empty_o); // R7

endmodule

// File: rtl/wpf_csr.sv
module wpf_csr
    import wpf_pkg::*;
#(
    parameter int TRIG_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [2*TRIG_W+1:0]   wdata_i,
    output logic [2*TRIG_W+1:0]   ctrl_o,
    output logic [TRIG_W-1:0]     tx_trig_o,
    output logic [TRIG_W-1:0]     rx_trig_o,
    output logic [1:0]            busy_o,
    output logic [1:0]            clear_o
);
    // Index 1 is the transmit direction, index 0 the receive direction,
    // matching the flush bit positions in the control word.
    typedef struct packed {
        logic [TRIG_W-1:0] tx_trig;
        logic [TRIG_W-1:0] rx_trig;
        flush_st_t [1:0]   fl;
    } csr_st_t;

    csr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < 2; i++) begin
            if (st_q.fl[i].pend && !st_q.fl[i].stage) begin
                st_d.fl[i].stage = 1'b1;
            end else if (st_q.fl[i].pend) begin
                st_d.fl[i] = '0;
            end
        end
        if (wr_i) begin
            st_d.tx_trig = wdata_i[2*TRIG_W+1 -: TRIG_W];
            st_d.rx_trig = wdata_i[TRIG_W+1 -: TRIG_W];
            for (int i = 0; i < 2; i++) begin
                if (wdata_i[i] && !st_q.fl[i].pend) begin
                    st_d.fl[i].pend  = 1'b1;
                    st_d.fl[i].stage = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int i = 0; i < 2; i++) begin
            busy_o[i]  = st_q.fl[i].pend;
            clear_o[i] = st_q.fl[i].pend && !st_q.fl[i].stage;
        end
    end

    assign tx_trig_o = st_q.tx_trig;
    assign rx_trig_o = st_q.rx_trig;
    assign ctrl_o    = {st_q.tx_trig, st_q.rx_trig, busy_o};

    AST_FLUSH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o[1] && !clear_o[1]) |=> !busy_o[1]); // R7

endmodule

// File: rtl/wpfifo_ctrl.sv
module wpfifo_ctrl
    import wpf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int TRIG_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              eng_tx_valid_o,
    output logic [DATA_W-1:0] eng_tx_data_o,
    input  logic              eng_tx_ready_i,
    input  logic              eng_rx_valid_i,
    input  logic [DATA_W-1:0] eng_rx_data_i,
    output logic              eng_rx_ready_o,
    output logic              tx_req_o,
    output logic              rx_req_o,
    output logic              tx_ovf_o,
    output logic              rx_unf_o
);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int CTRL_W = 2 * TRIG_W + 2;
    localparam int CMP_W  = ((CNT_W > TRIG_W) ? CNT_W : TRIG_W) + 1;

    logic [CTRL_W-1:0] ctrl_vec;
    logic [TRIG_W-1:0] tx_trig, rx_trig;
    logic [1:0]        busy, clear;
    logic              tx_busy, rx_busy, tx_clear, rx_clear;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt, tx_free;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0] rx_head;
    logic              tx_wr_hit, rx_rd_hit, tx_push, rx_pop, tx_pop, rx_push;
    err_st_t           err_d, err_q;

    wpf_csr #(.TRIG_W(TRIG_W)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (bus_wr_i && (bus_addr_i == ADR_CTRL)),
        .wdata_i   (bus_wdata_i[CTRL_W-1:0]),
        .ctrl_o    (ctrl_vec),
        .tx_trig_o (tx_trig),
        .rx_trig_o (rx_trig),
        .busy_o    (busy),
        .clear_o   (clear)
    );

    assign tx_busy  = busy[1];
    assign rx_busy  = busy[0];
    assign tx_clear = clear[1];
    assign rx_clear = clear[0];

    assign tx_wr_hit = bus_wr_i && (bus_addr_i == ADR_TXDATA) && !tx_busy;
    assign rx_rd_hit = bus_rd_i && (bus_addr_i == ADR_RXDATA) && !rx_busy;
    assign tx_push   = tx_wr_hit;
    assign rx_pop    = rx_rd_hit;
    assign tx_pop    = eng_tx_valid_o && eng_tx_ready_i;
    assign rx_push   = eng_rx_valid_i && eng_rx_ready_o;

    wpf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (tx_clear),
        .push_i      (tx_push),
        .push_data_i (bus_wdata_i),
        .pop_i       (tx_pop),
        .head_o      (eng_tx_data_o),
        .count_o     (tx_cnt),
        .full_o      (tx_full),
        .empty_o     (tx_empty)
    );

    wpf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (rx_clear),
        .push_i      (rx_push),
        .push_data_i (eng_rx_data_i),
        .pop_i       (rx_pop),
        .head_o      (rx_head),
        .count_o     (rx_cnt),
        .full_o      (rx_full),
        .empty_o     (rx_empty)
    );

    assign eng_tx_valid_o = !tx_empty && !tx_busy;
    assign eng_rx_ready_o = !rx_full && !rx_busy;

    assign tx_free  = CNT_W'(DEPTH) - tx_cnt;
    assign tx_req_o = CMP_W'(tx_free) >= (CMP_W'(tx_trig) + CMP_W'(1));
    assign rx_req_o = CMP_W'(rx_cnt)  >= (CMP_W'(rx_trig) + CMP_W'(1));

    always_comb begin
        err_d = err_q;
        if (tx_clear)                   err_d.ovf = 1'b0;
        else if (tx_wr_hit && tx_full)  err_d.ovf = 1'b1;
        if (rx_clear)                   err_d.unf = 1'b0;
        else if (rx_rd_hit && rx_empty) err_d.unf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign tx_ovf_o = err_q.ovf;
    assign rx_unf_o = err_q.unf;

    always_comb begin
        unique case (bus_addr_i)
            ADR_RXDATA: bus_rdata_o = rx_empty ? '0 : rx_head;
            ADR_CTRL:   bus_rdata_o = DATA_W'(ctrl_vec);
            ADR_STAT:   bus_rdata_o = DATA_W'({tx_free, rx_cnt});
            default:    bus_rdata_o = '0;
        endcase
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ovf_o && !tx_clear) |=> tx_ovf_o); // R5
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_unf_o && !rx_clear) |=> rx_unf_o); // R6
    AST_TX_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> tx_empty); // R7
    AST_RX_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_busy) |-> rx_empty); // R7
    AST_NO_RX_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && eng_rx_valid_i && !rx_pop && !rx_clear) |=> rx_full); // R9

endmodule

// File: tb/wpfifo_ctrl_bench.sv
module wpfifo_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid, tx_ready = 1'b0;
    logic [31:0] tx_data;
    logic        rx_valid = 1'b0, rx_ready;
    logic [31:0] rx_data = '0;
    logic        tx_req, rx_req, tx_ovf, rx_unf;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] tx_exp[$];
    logic [31:0] rx_exp[$];

    always #10 clk = ~clk;   // 50 MHz

    wpfifo_ctrl u_wpfifo_ctrl (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .eng_tx_valid_o(tx_valid), .eng_tx_data_o(tx_data), .eng_tx_ready_i(tx_ready),
        .eng_rx_valid_i(rx_valid), .eng_rx_data_i(rx_data), .eng_rx_ready_o(rx_ready),
        .tx_req_o(tx_req), .rx_req_o(rx_req), .tx_ovf_o(tx_ovf), .rx_unf_o(rx_unf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic sw_tx(input logic [31:0] w);
        reg_wr(2'd0, w);
        tx_exp.push_back(w);
    endtask

    task automatic eng_push(input logic [31:0] w);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_data = w;
        @(posedge clk); #1;
        rx_valid = 1'b0;
        rx_exp.push_back(w);
    endtask

    task automatic sw_rx_read();
        logic [31:0] e;
        @(posedge clk); #1;
        bus_addr = 2'd1; bus_rd = 1'b1;
        @(negedge clk);
        e = rx_exp.pop_front();
        chk("R3 rx order", bus_rdata, e);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic drain_tx();
        @(posedge clk); #1;
        tx_ready = 1'b1;
        for (int k = 0; k < 50 && tx_exp.size() > 0; k++) begin
            @(posedge clk); #1;
        end
        tx_ready = 1'b0;
        chk("R2 tx drained", 32'(tx_exp.size()), 32'd0);
    endtask

    // Monitor: compares each word the engine takes against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (tx_exp.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R2 unexpected tx word actual=%0h expected=none", tx_data);
            end else begin
                chk("R2 tx order", tx_data, tx_exp.pop_front());
            end
        end
    end

    initial begin
        #4000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        peek(2'd3, v); chk("R1 status", v, 32'h80);
        peek(2'd2, v); chk("R1 ctrl", v, 32'h0);
        chk("R1 tx_req", 32'(tx_req), 32'd1);
        chk("R1 rx_req", 32'(rx_req), 32'd0);
        chk("R1 ovf", 32'(tx_ovf), 32'd0);
        chk("R1 unf", 32'(rx_unf), 32'd0);
        chk("R1 tx_valid", 32'(tx_valid), 32'd0);
        chk("R1 rx_ready", 32'(rx_ready), 32'd1);

        // R2/R4 small burst
        for (int i = 0; i < 3; i++) sw_tx(32'hA000_0000 + 32'(i));
        peek(2'd3, v); chk("R4 status 3 tx", v, 32'h50);
        drain_tx();
        peek(2'd3, v); chk("R4 status drained", v, 32'h80);

        // R5 fill and overflow
        for (int i = 0; i < 8; i++) sw_tx(32'hB000_0000 + 32'(i * 17));
        peek(2'd3, v); chk("R4 status tx full", v, 32'h00);
        chk("R8 tx_req at zero free", 32'(tx_req), 32'd0);
        reg_wr(2'd0, 32'hDEAD_BEEF);
        chk("R5 ovf set", 32'(tx_ovf), 32'd1);
        peek(2'd3, v); chk("R5 count unchanged", v, 32'h00);
        drain_tx();
        chk("R5 ovf sticky", 32'(tx_ovf), 32'd1);

        sw_tx(32'hC000_0000);
        sw_tx(32'hC000_0001);

        // R3/R8 receive path and threshold
        for (int i = 0; i < 5; i++) eng_push(32'hD000_0000 + 32'(i * 3));
        peek(2'd3, v); chk("R4 status rx5 tx2", v, 32'h65);
        chk("R8 rx_req trig0", 32'(rx_req), 32'd1);
        reg_wr(2'd2, 32'h14);
        peek(2'd2, v); chk("R8 ctrl readback", v, 32'h14);
        chk("R8 rx_req below level", 32'(rx_req), 32'd0);
        eng_push(32'hD000_0055);
        chk("R8 rx_req at level", 32'(rx_req), 32'd1);
        for (int i = 0; i < 6; i++) sw_rx_read();
        peek(2'd3, v); chk("R3 status after reads", v, 32'h60);

        // R6 underflow
        @(posedge clk); #1;
        bus_addr = 2'd1; bus_rd = 1'b1;
        @(negedge clk);
        chk("R6 empty read data", bus_rdata, 32'h0);
        @(posedge clk); #1;
        bus_rd = 1'b0;
        chk("R6 unf set", 32'(rx_unf), 32'd1);
        peek(2'd3, v); chk("R6 count unchanged", v, 32'h60);

        // R9 full receive queue
        for (int i = 0; i < 8; i++) eng_push(32'hE000_0000 + 32'(i));
        chk("R9 rx_ready low when full", 32'(rx_ready), 32'd0);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_data = 32'h0000_0BAD;
        @(posedge clk); #1;
        rx_valid = 1'b0;
        peek(2'd3, v); chk("R9 offered word dropped", v, 32'h68);

        // R7 receive flush
        reg_wr(2'd2, 32'h15);
        peek(2'd2, v); chk("R7 rx flush bit high", v, 32'h15);
        chk("R9 rx_ready low in flush", 32'(rx_ready), 32'd0);
        peek(2'd3, v); chk("R7 rx emptied tx kept", v, 32'h60);
        peek(2'd2, v); chk("R7 rx flush bit cleared", v, 32'h14);
        chk("R7 unf cleared", 32'(rx_unf), 32'd0);
        chk("R7 ovf untouched", 32'(tx_ovf), 32'd1);
        rx_exp.delete();

        // R8 transmit threshold
        reg_wr(2'd2, 32'h74);
        chk("R8 tx_req free6 level3", 32'(tx_req), 32'd1);
        for (int i = 0; i < 3; i++) sw_tx(32'hF000_0000 + 32'(i));
        chk("R8 tx_req free3 level3", 32'(tx_req), 32'd0);
        peek(2'd2, v); chk("R8 ctrl readback tx", v, 32'h74);

        // R7 transmit flush
        reg_wr(2'd2, 32'h76);
        peek(2'd2, v); chk("R7 tx flush bit high", v, 32'h76);
        peek(2'd3, v); chk("R7 tx emptied", v, 32'h80);
        peek(2'd2, v); chk("R7 tx flush bit cleared", v, 32'h74);
        chk("R7 ovf cleared", 32'(tx_ovf), 32'd0);
        chk("R2 tx_valid after flush", 32'(tx_valid), 32'd0);
        tx_exp.delete();

        // R2 traffic after flush
        sw_tx(32'h1234_5678);
        drain_tx();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule